// File: doc/BRIEF.md
# Predicate Break-After Scan Unit

This unit turns a governing mask predicate and a source predicate into a "break-after" predicate. It holds one bit per byte lane. The lanes are walked in ascending order, and only active lanes (mask bit 1) take part in the walk. Each active lane is set until the walk reaches the first active lane whose source bit is true. That lane is still set, and every active lane after it is cleared. Inactive lanes play no part in the walk. A mode pin selects what happens to them: either they copy the corresponding bit of an old destination predicate, or they are forced to 0.

An elaboration parameter adds a flag-setting variant. It reports N, Z, C and V condition codes that describe the result as seen through the mask. Operands enter through a valid/ready handshake, and the result and flags are captured in a single output register. The result stays on the output until the consumer accepts it.

Back-pressure works as follows. An operand set is accepted on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is high when the output register is empty, or when its contents are being accepted on that same edge. Once `out_valid` rises, it stays high and `out_pred` and `out_flags` stay constant until an edge where `out_ready` is high.

Top module: `pred_break_after`

## Requirements
- R1: On active lanes, the result is 1 from the lowest active lane up to and including the first active lane whose source bit is 1, and 0 on every active lane above that one.
- R2: When no active lane has a source bit of 1, every active lane of the result is 1.
- R3: With `merge_mode` = 1, each inactive lane of the result equals the same lane of `old_pred`.
- R4: With `merge_mode` = 0, each inactive lane of the result is 0.
- R5: A source bit of 1 on an inactive lane does not end the scan; active lanes above it are still set.
- R6: `out_flags[3]` (N) equals the result bit of the lowest-numbered active lane, and is 0 when no lane is active.
- R7: `out_flags[2]` (Z) is 1 exactly when no active lane of the result is 1.
- R8: `out_flags[1]` (C) is the inverse of the result bit of the highest-numbered active lane, and is 1 when no lane is active. `out_flags[0]` (V) is always 0. With `SET_FLAGS` = 0, all four flag bits are 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. A transfer accepted on an edge appears on `out_pred`/`out_flags` with `out_valid` high right after that same edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pred` and `out_flags` hold their values.
- R11: After reset, `out_valid`, `out_pred` and `out_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| mask | input | LANES | Governing predicate, 1 = active lane |
| src | input | LANES | Source predicate scanned for the break |
| old_pred | input | LANES | Previous destination, used for merging |
| merge_mode | input | 1 | 1 = merge inactive lanes, 0 = zero them |
| out_valid | output | 1 | Result register holds an unaccepted result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pred | output | LANES | Break-after result predicate |
| out_flags | output | 4 | {N, Z, C, V} condition flags |

## Verification
Results are due exactly one clock edge after acceptance. The operand set that meets `in_valid && in_ready` on an edge must appear on the outputs right after that edge. The bench drives inputs shortly after each rising edge and samples the ports at the falling edge. At that point it predicts acceptance from the settled `in_ready`, and pushes the reference result into a queue whose head must match the outputs at every later falling edge until `out_ready` takes it. This keeps the handshake timing (R9) and the hold rule (R10) under check on every clock, while `out_ready` is varied at random.

// File: rtl/pbrk_pkg.sv
package pbrk_pkg;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } pbrk_flags_t;
endpackage

// File: rtl/pbrk_scan.sv
module pbrk_scan #(
  parameter int LANES = 16
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] src,
  input  logic [LANES-1:0] old_pred,
  input  logic             merge_mode,
  output logic [LANES-1:0] result
);
  // Running break flag: only active lanes read or update it.
  always_comb begin
    logic broken;
    broken = 1'b0;
    result = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i]) begin
        result[i] = ~broken;
        broken    = broken | src[i];
      end else begin
        result[i] = merge_mode & old_pred[i];
      end
    end
  end
endmodule

// File: rtl/pbrk_flags.sv
module pbrk_flags
  import pbrk_pkg::*;
#(
  parameter int LANES     = 16,
  parameter bit SET_FLAGS = 1'b1
) (
  input  logic [LANES-1:0] mask,
  input  logic [LANES-1:0] result,
  output pbrk_flags_t      flags
);
  generate
    if (SET_FLAGS) begin : g_flags
      always_comb begin
        logic seen;
        logic first_bit;
        logic last_bit;
        logic any_set;
        seen      = 1'b0;
        first_bit = 1'b0;
        last_bit  = 1'b0;
        any_set   = 1'b0;
        for (int i = 0; i < LANES; i++) begin
          if (mask[i]) begin
            if (!seen) first_bit = result[i];
            seen     = 1'b1;
            last_bit = result[i];
            any_set  = any_set | result[i];
          end
        end
        flags.n = first_bit;
        flags.z = ~any_set;
        flags.c = ~last_bit;
        flags.v = 1'b0;
      end
    end else begin : g_noflags
      assign flags = '0;
    end
  endgenerate
endmodule

// File: rtl/pbrk_hold.sv
module pbrk_hold
  import pbrk_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LANES-1:0] next_pred,
  input  pbrk_flags_t      next_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LANES-1:0] out_pred,
  output pbrk_flags_t      out_flags
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pred  <= '0;
      out_flags <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pred  <= next_pred;
      out_flags <= next_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pred_break_after.sv
module pred_break_after
  import pbrk_pkg::*;
#(
  parameter int LANES     = 16,
  parameter bit SET_FLAGS = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES-1:0]    mask,
  input  logic [LANES-1:0]    src,
  input  logic [LANES-1:0]    old_pred,
  input  logic                merge_mode,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES-1:0]    out_pred,
  output logic [FLAG_W-1:0]   out_flags
);
  localparam int BYTES = LANES / 8;

  logic [LANES-1:0] scan_res;
  pbrk_flags_t      scan_flags;
  pbrk_flags_t      held_flags;

  generate
    if (BYTES * 8 != LANES || BYTES == 0) begin : g_bad_lanes
      $error("LANES must be a nonzero multiple of 8");
    end
  endgenerate

  pbrk_scan #(.LANES(LANES)) u_scan (
    .mask       (mask),
    .src        (src),
    .old_pred   (old_pred),
    .merge_mode (merge_mode),
    .result     (scan_res)
  );

  pbrk_flags #(.LANES(LANES), .SET_FLAGS(SET_FLAGS)) u_flags (
    .mask   (mask),
    .result (scan_res),
    .flags  (scan_flags)
  );

  pbrk_hold #(.LANES(LANES)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .next_pred  (scan_res),
    .next_flags (scan_flags),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_pred   (out_pred),
    .out_flags  (held_flags)
  );

  assign out_flags = held_flags;
endmodule

// File: rtl/pbrk_chk.sv
module pbrk_chk #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] mask,
  input logic             merge_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LANES-1:0] out_pred,
  input logic [3:0]       out_flags
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pred) && $stable(out_flags)); // R10

  AST_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !merge_mode |=> (out_pred & ~$past(mask)) == '0); // R4

  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[0]); // R8

  AST_N_EXCLUDES_Z: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[3] |-> !out_flags[2]); // R7
endmodule

bind pred_break_after pbrk_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .mask       (mask),
  .merge_mode (merge_mode),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pred   (out_pred),
  .out_flags  (out_flags)
);

// File: tb/pred_break_after_test.sv
module pred_break_after_test;
  localparam int L = 16;

  typedef struct {
    logic [L-1:0] pred;
    logic [3:0]   flags;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [L-1:0] mask = '0;
  logic [L-1:0] src = '0;
  logic [L-1:0] old_pred = '0;
  logic merge_mode = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [L-1:0] out_pred;
  logic [3:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  string cur_tag = "R1";
  exp_t q[$];

  always #10 clk = ~clk;

  pred_break_after #(.LANES(L), .SET_FLAGS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mask(mask), .src(src), .old_pred(old_pred), .merge_mode(merge_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_pred(out_pred),
    .out_flags(out_flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model straight from the requirements.
  function automatic exp_t model(input logic [L-1:0] m, input logic [L-1:0] s,
                                 input logic [L-1:0] o, input logic mm, input string tag);
    exp_t e;
    int first_true = L;
    int lo = -1;
    int hi = -1;
    int ones = 0;
    for (int i = 0; i < L; i++)
      if (m[i] && s[i] && first_true == L) first_true = i;
    for (int i = 0; i < L; i++) begin
      if (m[i]) e.pred[i] = (i <= first_true);
      else      e.pred[i] = mm ? o[i] : 1'b0;
    end
    for (int i = 0; i < L; i++)
      if (m[i]) begin
        if (lo < 0) lo = i;
        hi = i;
        if (e.pred[i]) ones++;
      end
    e.flags[3] = (lo >= 0) ? e.pred[lo] : 1'b0;
    e.flags[2] = (ones == 0);
    e.flags[1] = (hi >= 0) ? ~e.pred[hi] : 1'b1;
    e.flags[0] = 1'b0;
    e.tag = tag;
    return e;
  endfunction

  // Compare every falling edge, then predict the coming edge's transfers.
  always @(negedge clk) begin
    if (running) begin
      if (q.size() > 0) begin
        check("R9/R10 out_valid", {31'b0, out_valid}, 32'd1);
        check({q[0].tag, " pred"}, {16'b0, out_pred}, {16'b0, q[0].pred});
        check({q[0].tag, " R6/R7/R8 flags"}, {28'b0, out_flags}, {28'b0, q[0].flags});
      end else begin
        check("R9 out_valid idle", {31'b0, out_valid}, 32'd0);
      end
      check("R9 in_ready", {31'b0, in_ready}, {31'b0, (q.size() == 0) || out_ready});
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      if (in_valid && in_ready) q.push_back(model(mask, src, old_pred, merge_mode, cur_tag));
    end
  end

  task automatic send(input logic [L-1:0] m, input logic [L-1:0] s,
                      input logic [L-1:0] o, input logic mm, input string tag);
    bit acc;
    mask = m; src = s; old_pred = o; merge_mode = mm; cur_tag = tag;
    in_valid = 1'b1;
    forever begin
      #1 acc = in_ready;
      @(posedge clk); #2;
      out_ready = ($urandom_range(0, 3) != 0);
      if (acc) break;
    end
    in_valid = 1'b0;
    if ($urandom_range(0, 4) == 0) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R11 out_valid", {31'b0, out_valid}, 32'd0);
    check("R11 out_pred", {16'b0, out_pred}, 32'd0);
    check("R11 out_flags", {28'b0, out_flags}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    running = 1'b1;
    out_ready = 1'b1;

    send(16'h0000, 16'hFFFF, 16'hA5A5, 1'b1, "R8 all inactive merge");
    send(16'h0000, 16'hFFFF, 16'hA5A5, 1'b0, "R8 all inactive zero");
    send(16'hF0F0, 16'h0000, 16'h0F0F, 1'b1, "R2 all false merge");
    send(16'hFFFF, 16'h0000, 16'h0000, 1'b0, "R2 all false full");
    send(16'hFF00, 16'h0100, 16'h00FF, 1'b0, "R1 first active lane");
    send(16'hFFFF, 16'h8000, 16'h0000, 1'b0, "R1 last lane only");
    send(16'h00F0, 16'h000F, 16'h0000, 1'b0, "R5 inactive true");
    send(16'h0FF0, 16'h0080, 16'hF00F, 1'b1, "R3 merge");
    send(16'h0FF0, 16'h0080, 16'hF00F, 1'b0, "R4 zero");
    send(16'h0001, 16'h0001, 16'h0000, 1'b0, "R6 single lane");

    // Back-to-back under varying back-pressure.
    for (int k = 0; k < 400; k++) begin
      logic [L-1:0] m;
      logic [L-1:0] s;
      m = L'($urandom);
      s = L'($urandom) & L'($urandom);
      if (k % 7 == 0) s = '0;
      send(m, s, L'($urandom), k[0], "R1/R3/R4/R5 random");
    end

    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule